// File: doc/BRIEF.md
# Level-Threshold Interrupt Arbiter

This block picks one of eight maskable interrupt sources and hands it to the processor. Each source has a request flag and a 3-bit priority level. A source can be accepted only when three things hold: the global interrupt enable is set, the source has a pending request, and its level is strictly above the current processor priority threshold. Among the sources that qualify, the one with the highest level wins. When two or more qualifying sources share that level, the lowest index wins. The winner is reported as a one-cycle acknowledge that carries its index and level.

Software can write the threshold in two ways, and each way has its own latency before the new value is used. A return-style update is used two cycles later. A load-style update is used three cycles later. A per-source level write is used three cycles later. The enable flag is written directly.

When a source is accepted, the block does three things in the same cycle. It raises the threshold to the accepted level, it clears the enable flag, and it clears the winner's request. Any threshold update still waiting in the delay is thrown away. This stops the next interrupt until software restores the context.

Top module: `irq_level_arbiter`

## Requirements
- R1: Level code 0 means the source is disabled. Codes 1 to 7 are levels 1 to 7, and 7 is the highest. A source whose level is 0 is never acknowledged, even with a pending request, enable set and threshold 0.
- R2: A source is acknowledged only if the enable flag is 1, its request is pending, and its level is strictly greater than the threshold. A level equal to the threshold is not accepted.
- R3: A threshold of 0 accepts levels 1 and up, and each step up in the threshold raises the minimum level by one. A threshold of 7 blocks every source.
- R4: Among the eligible sources, the highest level wins. If several share that level, the lowest index wins.
- R5: A one-cycle pulse on `req_set[i]` sets request bit i. The bit stays set until source i is acknowledged or `req_clr[i]` is pulsed. When set and clear arrive in the same cycle, set wins. `req_pending` shows the bits one cycle after the strobe.
- R6: `ack` is registered. It rises in the cycle after a cycle in which a source was eligible and `cpu_ready` was 1, and it lasts one cycle. `ack_idx` and `ack_lvl` give the winner. While `cpu_ready` is 0, no acknowledge is issued.
- R7: In the cycle an acknowledge is issued, three things happen at once. The threshold takes the accepted level, the enable flag becomes 0, and the winner's request is cleared. A threshold update still waiting in the delay is discarded. These actions take precedence over threshold or enable writes in the same cycle.
- R8: A threshold write with `ipl_wr_kind`=0 (return-style) appears on `ipl_cur` and is used for arbitration starting two cycles after the strobe cycle.
- R9: A threshold write with `ipl_wr_kind`=1 (load-style) is used starting three cycles after the strobe cycle.
- R10: A per-source level write is used for arbitration starting three cycles after the strobe cycle. As a result, an acknowledge it enables appears four cycles after the strobe.
- R11: The enable flag, the per-source levels and the threshold are independent of each other. Writing one never changes another. An enable write appears on `ien_cur` one cycle after the strobe.
- R12: After reset there is no acknowledge, the threshold is 0, the enable flag is 0, no request is pending, and every level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | 8 | One-cycle request pulses, one bit per source |
| req_clr | input | 8 | Software clear strobes for the request bits |
| lvl_wr_en | input | 1 | Per-source level write strobe |
| lvl_wr_idx | input | 3 | Source whose level is written |
| lvl_wr_data | input | 3 | New level value |
| ipl_wr_en | input | 1 | Threshold write strobe |
| ipl_wr_kind | input | 1 | 0 = return-style (2-cycle delay), 1 = load-style (3-cycle delay) |
| ipl_wr_data | input | 3 | New threshold value |
| ien_wr_en | input | 1 | Enable flag write strobe |
| ien_wr_data | input | 1 | New enable flag value |
| cpu_ready | input | 1 | Processor can take an interrupt |
| ack | output | 1 | One-cycle acknowledge pulse |
| ack_idx | output | 3 | Index of the acknowledged source |
| ack_lvl | output | 3 | Level of the acknowledged source |
| ipl_cur | output | 3 | Threshold currently used for arbitration |
| ien_cur | output | 1 | Current enable flag |
| req_pending | output | 8 | Pending request bits |

## Verification
Each result has a fixed latency, counted in negedges after the negedge that drives the stimulus:
- Request and enable changes show on the ports at the first negedge.
- A return-style threshold write shows at the second negedge. A load-style write shows at the third.
- An acknowledge needs one register stage beyond eligibility. It therefore appears two negedges after an enable write, one negedge after `cpu_ready` rises, and four negedges after a level write.

The bench samples only on negedges. At each delayed update it checks the old value on the negedge before the due one and the new value on the due negedge, so a result one cycle early or one cycle late is reported.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic {UPD_RETURN = 1'b0, UPD_LOAD = 1'b1} upd_kind_e;
endpackage

// File: rtl/irq_delayed_reg.sv
// Register whose writes become visible after a programmable countdown.
// A force load takes effect at once and discards any waiting write.
module irq_delayed_reg #(
  parameter int W         = 3,
  parameter int SHORT_DLY = 2,
  parameter int LONG_DLY  = 3,
  localparam int CW       = $clog2(LONG_DLY + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_long,
  input  logic [W-1:0] wr_data,
  input  logic         force_en,
  input  logic [W-1:0] force_data,
  output logic [W-1:0] q
);
  logic [W-1:0]  q_r, q_n;
  logic [W-1:0]  pv_r, pv_n;
  logic [CW-1:0] pc_r, pc_n;

  always_comb begin
    q_n  = q_r;
    pv_n = pv_r;
    pc_n = pc_r;
    if (pc_r == CW'(1)) begin
      q_n  = pv_r;
      pc_n = '0;
    end else if (pc_r != '0) begin
      pc_n = pc_r - CW'(1);
    end
    if (wr_en) begin
      pv_n = wr_data;
      pc_n = wr_long ? CW'(LONG_DLY - 1) : CW'(SHORT_DLY - 1);
    end
    if (force_en) begin
      q_n  = force_data;
      pc_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r  <= '0;
      pv_r <= '0;
      pc_r <= '0;
    end else begin
      q_r  <= q_n;
      pv_r <= pv_n;
      pc_r <= pc_n;
    end
  end

  assign q = q_r;

  assert_force_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |=> (q == $past(force_data)));
  assert_delayed_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_r == CW'(1) && !force_en) |=> (q == $past(pv_r)));
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_r == '0 && !force_en) |=> $stable(q));
endmodule

// File: rtl/irq_req_flags.sv
// Sticky request bits: set wins over both clear sources.
module irq_req_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_r, pend_n;

  always_comb pend_n = (pend_r & ~(clr_i | ack_clr_i)) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_r <= '0;
    else        pend_r <= pend_n;
  end

  assign pend_o = pend_r;

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_r & $past(set_i)) == $past(set_i)));
  assert_no_self_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~pend_r & ~set_i)) |=> ((pend_r & ~$past(pend_r) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_winner_select.sv
// Highest level wins; strict compare while scanning upward keeps lowest index on ties.
module irq_winner_select
  import irq_arb_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       elig,
  input  lvl_t [N-1:0]       lvls,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output lvl_t               lvl
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (lvls[i] > lvl)) begin
        any = 1'b1;
        idx = IDX_W'(i);
        lvl = lvls[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int RET_DLY   = 2,
  parameter int LOAD_DLY  = 3,
  parameter int SRC_DLY   = 3,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_set,
  input  logic [NUM_SRC-1:0] req_clr,
  input  logic               lvl_wr_en,
  input  logic [IDX_W-1:0]   lvl_wr_idx,
  input  logic [LVL_W-1:0]   lvl_wr_data,
  input  logic               ipl_wr_en,
  input  logic               ipl_wr_kind,
  input  logic [LVL_W-1:0]   ipl_wr_data,
  input  logic               ien_wr_en,
  input  logic               ien_wr_data,
  input  logic               cpu_ready,
  output logic               ack,
  output logic [IDX_W-1:0]   ack_idx,
  output logic [LVL_W-1:0]   ack_lvl,
  output logic [LVL_W-1:0]   ipl_cur,
  output logic               ien_cur,
  output logic [NUM_SRC-1:0] req_pending
);
  lvl_t [NUM_SRC-1:0] src_lvl;
  lvl_t               ipl_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] ack_clr;
  logic               win_any;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  logic               take;

  logic               ien_r, ien_n;
  logic               ack_r, ack_n;
  logic [IDX_W-1:0]   aidx_r, aidx_n;
  lvl_t               alvl_r, alvl_n;

  // Threshold register: kind selects return (short) or load (long) latency.
  irq_delayed_reg #(.W(LVL_W), .SHORT_DLY(RET_DLY), .LONG_DLY(LOAD_DLY)) i_ipl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ipl_wr_en), .wr_long(ipl_wr_kind == UPD_LOAD), .wr_data(ipl_wr_data),
    .force_en(take), .force_data(win_lvl), .q(ipl_q)
  );

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      irq_delayed_reg #(.W(LVL_W), .SHORT_DLY(SRC_DLY), .LONG_DLY(SRC_DLY)) i_lvl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lvl_wr_en && (lvl_wr_idx == IDX_W'(g))), .wr_long(1'b1),
        .wr_data(lvl_wr_data), .force_en(1'b0), .force_data('0), .q(src_lvl[g])
      );
      assign elig[g]    = pend[g] & ien_r & (src_lvl[g] > ipl_q);
      assign ack_clr[g] = take & (win_idx == IDX_W'(g));
    end
  endgenerate

  irq_req_flags #(.N(NUM_SRC)) i_req (
    .clk(clk), .rst_n(rst_n), .set_i(req_set), .clr_i(req_clr),
    .ack_clr_i(ack_clr), .pend_o(pend)
  );

  irq_winner_select #(.N(NUM_SRC)) i_win (
    .elig(elig), .lvls(src_lvl), .any(win_any), .idx(win_idx), .lvl(win_lvl)
  );

  assign take = win_any & cpu_ready;

  always_comb begin
    ack_n  = take;
    aidx_n = take ? win_idx : aidx_r;
    alvl_n = take ? win_lvl : alvl_r;
    ien_n  = ien_r;
    if (ien_wr_en) ien_n = ien_wr_data;
    if (take)      ien_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_r  <= 1'b0;
      ack_r  <= 1'b0;
      aidx_r <= '0;
      alvl_r <= '0;
    end else begin
      ien_r  <= ien_n;
      ack_r  <= ack_n;
      aidx_r <= aidx_n;
      alvl_r <= alvl_n;
    end
  end

  assign ack         = ack_r;
  assign ack_idx     = aidx_r;
  assign ack_lvl     = alvl_r;
  assign ipl_cur     = ipl_q;
  assign ien_cur     = ien_r;
  assign req_pending = pend;

  assert_nonzero_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ack_lvl != '0));
  assert_strict_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ack_lvl > $past(ipl_q)) && $past(ien_r));
  assert_was_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (($past(pend) & (NUM_SRC'(1) << ack_idx)) != '0));
  assert_top_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_q == '1) |=> !ack);
  assert_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(cpu_ready));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_ack_side_effects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ipl_q == ack_lvl) && !ien_r);
endmodule

// File: tb/test_irq_level_arbiter.sv
`timescale 1ns/1ps
module test_irq_level_arbiter;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req_set, req_clr;
  logic         lvl_wr_en;
  logic [2:0]   lvl_wr_idx, lvl_wr_data;
  logic         ipl_wr_en, ipl_wr_kind;
  logic [2:0]   ipl_wr_data;
  logic         ien_wr_en, ien_wr_data;
  logic         cpu_ready;
  logic         ack;
  logic [2:0]   ack_idx, ack_lvl, ipl_cur;
  logic         ien_cur;
  logic [N-1:0] req_pending;

  irq_level_arbiter i_irq_level_arbiter (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
    .lvl_wr_en(lvl_wr_en), .lvl_wr_idx(lvl_wr_idx), .lvl_wr_data(lvl_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_kind(ipl_wr_kind), .ipl_wr_data(ipl_wr_data),
    .ien_wr_en(ien_wr_en), .ien_wr_data(ien_wr_data), .cpu_ready(cpu_ready),
    .ack(ack), .ack_idx(ack_idx), .ack_lvl(ack_lvl), .ipl_cur(ipl_cur),
    .ien_cur(ien_cur), .req_pending(req_pending)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_set = '0; req_clr = '0;
    lvl_wr_en = 0; lvl_wr_idx = '0; lvl_wr_data = '0;
    ipl_wr_en = 0; ipl_wr_kind = 0; ipl_wr_data = '0;
    ien_wr_en = 0; ien_wr_data = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle_inputs(); cpu_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_lvl(input int s, input logic [2:0] v);
    lvl_wr_en = 1; lvl_wr_idx = 3'(s); lvl_wr_data = v;
    @(negedge clk); lvl_wr_en = 0;
  endtask

  task automatic wr_ipl(input logic kind, input logic [2:0] v);
    ipl_wr_en = 1; ipl_wr_kind = kind; ipl_wr_data = v;
    @(negedge clk); ipl_wr_en = 0;
  endtask

  task automatic wr_ien(input logic v);
    ien_wr_en = 1; ien_wr_data = v;
    @(negedge clk); ien_wr_en = 0;
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    req_set = m;
    @(negedge clk); req_set = '0;
  endtask

  typedef struct packed {
    logic [23:0] lv;   // level of source i at bits [3i+2:3i]
    logic [7:0]  req;
    logic [2:0]  ipl;
    logic        ex_ack;
    logic [2:0]  ex_idx;
    logic [2:0]  ex_lvl;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{24'hFAC688, 8'hFF, 3'd0, 1'b1, 3'd7, 3'd7},  // R4 highest level wins
    '{24'hFAC688, 8'h01, 3'd0, 1'b0, 3'd0, 3'd0},  // R1 level 0 never wins
    '{24'hB6DB6D, 8'hF0, 3'd4, 1'b1, 3'd4, 3'd5},  // R4 tie -> lowest index
    '{24'hB6DB6D, 8'hFF, 3'd5, 1'b0, 3'd0, 3'd0},  // R2 equal level refused
    '{24'hFFFFFF, 8'hFF, 3'd7, 1'b0, 3'd0, 3'd0},  // R3 threshold 7 blocks all
    '{24'h030F80, 8'h24, 3'd0, 1'b1, 3'd2, 3'd6},  // R4 level-7 source not pending
    '{24'h000010, 8'h02, 3'd1, 1'b1, 3'd1, 3'd2},  // R2 one above threshold
    '{24'h6DB6DB, 8'h80, 3'd2, 1'b1, 3'd7, 3'd3}   // R3 threshold 2 accepts 3
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..: run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    do_reset();
    chk("R12 ack after reset", ack, 0);
    chk("R12 ipl after reset", ipl_cur, 0);
    chk("R12 ien after reset", ien_cur, 0);
    chk("R12 pending after reset", req_pending, 0);

    // Vector walk: R1 R2 R3 R4
    for (int v = 0; v < 8; v++) begin
      do_reset();
      for (int s = 0; s < N; s++) wr_lvl(s, VEC[v].lv[3*s +: 3]);
      wr_ipl(1'b1, VEC[v].ipl);
      pulse_req(VEC[v].req);
      repeat (4) @(negedge clk);
      chk($sformatf("R6 vec%0d no ack while disabled", v), ack, 0);
      ien_wr_en = 1; ien_wr_data = 1;
      @(negedge clk); ien_wr_en = 0;
      chk($sformatf("R6 vec%0d ack not before register stage", v), ack, 0);
      @(negedge clk);
      chk($sformatf("R2 vec%0d ack", v), ack, VEC[v].ex_ack);
      if (VEC[v].ex_ack) begin
        chk($sformatf("R4 vec%0d ack_idx", v), ack_idx, VEC[v].ex_idx);
        chk($sformatf("R4 vec%0d ack_lvl", v), ack_lvl, VEC[v].ex_lvl);
      end
    end

    // R8 return-style threshold write: visible two cycles after strobe
    do_reset();
    ipl_wr_en = 1; ipl_wr_kind = 0; ipl_wr_data = 3'd3;
    @(negedge clk); ipl_wr_en = 0;
    chk("R8 ipl one cycle after return write", ipl_cur, 0);
    @(negedge clk);
    chk("R8 ipl two cycles after return write", ipl_cur, 3);

    // R9 load-style write: visible three cycles after strobe
    ipl_wr_en = 1; ipl_wr_kind = 1; ipl_wr_data = 3'd5;
    @(negedge clk); ipl_wr_en = 0;
    chk("R9 ipl one cycle after load write", ipl_cur, 3);
    @(negedge clk);
    chk("R9 ipl two cycles after load write", ipl_cur, 3);
    @(negedge clk);
    chk("R9 ipl three cycles after load write", ipl_cur, 5);

    // R11 independence and immediate enable write
    wr_ien(1'b1);
    chk("R11 ien one cycle after write", ien_cur, 1);
    chk("R11 ien write leaves ipl", ipl_cur, 5);
    wr_ipl(1'b0, 3'd6);
    @(negedge clk);
    chk("R11 ipl write applied", ipl_cur, 6);
    chk("R11 ipl write leaves ien", ien_cur, 1);
    chk("R11 ipl write leaves pending", req_pending, 0);

    // R10 per-source level latency, R1 level 0 ignored
    do_reset();
    wr_ien(1'b1);
    pulse_req(8'h10);
    chk("R5 pending after pulse", req_pending, 8'h10);
    @(negedge clk);
    chk("R1 level-0 source not acked", ack, 0);
    lvl_wr_en = 1; lvl_wr_idx = 3'd4; lvl_wr_data = 3'd4;
    @(negedge clk); lvl_wr_en = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 no ack three cycles after level write", ack, 0);
    @(negedge clk);
    chk("R10 ack four cycles after level write", ack, 1);
    chk("R10 ack_idx", ack_idx, 4);
    chk("R7 ipl takes accepted level", ipl_cur, 4);
    chk("R7 enable cleared on ack", ien_cur, 0);
    chk("R7 winner request cleared", req_pending, 0);
    @(negedge clk);
    chk("R6 ack is single cycle", ack, 0);

    // R6 cpu_ready gating
    do_reset();
    cpu_ready = 0;
    wr_lvl(0, 3'd1);
    repeat (4) @(negedge clk);
    pulse_req(8'h01);
    wr_ien(1'b1);
    repeat (3) @(negedge clk);
    chk("R6 no ack while not ready", ack, 0);
    cpu_ready = 1;
    @(negedge clk);
    chk("R6 ack after ready rises", ack, 1);
    chk("R6 ack_lvl", ack_lvl, 1);
    chk("R6 ack_idx", ack_idx, 0);

    // R7 acknowledge discards waiting threshold update
    do_reset();
    wr_lvl(3, 3'd4);
    repeat (4) @(negedge clk);
    pulse_req(8'h08);
    ipl_wr_en = 1; ipl_wr_kind = 1; ipl_wr_data = 3'd6;
    ien_wr_en = 1; ien_wr_data = 1;
    @(negedge clk); ipl_wr_en = 0; ien_wr_en = 0;
    chk("R7 no ack yet", ack, 0);
    @(negedge clk);
    chk("R7 ack before delayed threshold lands", ack, 1);
    chk("R7 ack_idx", ack_idx, 3);
    repeat (3) @(negedge clk);
    chk("R7 waiting threshold write discarded", ipl_cur, 4);

    // R5 set beats clear, clear alone drops the bit
    do_reset();
    req_set = 8'h41; req_clr = 8'h40;
    @(negedge clk); req_set = '0;
    chk("R5 set wins over clear", req_pending, 8'h41);
    req_clr = 8'h40;
    @(negedge clk); req_clr = '0;
    chk("R5 clear drops only its bit", req_pending, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule